// File: doc/BRIEF.md
# Multithreaded Thread Selection Unit

This unit decides, cycle by cycle, which of several hardware threads owns the fetch/issue slot of a shared pipeline. Each thread has its own program counter. The unit shows the program counter of the chosen thread next to the thread number and a valid flag.

Two policies are available, chosen by a single mode input. In interleaved (fine) mode, the slot rotates round-robin on every clock and passes over any thread whose ready line is low. In switch-on-event (coarse) mode, one thread keeps the slot until the caller reports an expensive stall, such as a second-level cache miss. The unit then moves to the next ready thread, pulses a flush request so the pipeline can be emptied or frozen, and raises a hold-commit signal for a fixed number of refill cycles while the new thread fills the pipeline.

The program counter of a thread steps forward only in cycles where that thread is granted. A redirect port can overwrite the program counter of any thread. Register files and the pipeline are outside this unit.

Top module: `mt_thread_sel`

## Requirements
- R1: In fine mode (`mode_coarse`=0), the granted thread is the first ready thread found by scanning upward and circularly from an internal pointer. After a grant, the pointer moves to the thread after the granted one, so with all threads ready the grant sequence is 0,1,2,3,0,...
- R2: In fine mode, a thread whose `thr_ready` bit is 0 is never granted. The rotation passes straight to the next ready thread.
- R3: In fine mode, when no `thr_ready` bit is set, `sel_valid` is 0 and the pointer keeps its value.
- R4: In coarse mode (`mode_coarse`=1), `sel_tid` stays on the current thread. `sel_valid` equals that thread's `thr_ready` bit. A stall with `long_stall`=0 causes no switch.
- R5: In coarse mode, `long_stall`=1 in a cycle where some other thread is ready moves `sel_tid` in the next cycle to the first ready thread after the current one, in circular order. `flush_req` is 1 during exactly that one cycle.
- R6: After a coarse switch, `hold_commit` is 1 for REFILL_CYC cycles (3 by default), starting with the cycle where `flush_req` is 1.
- R7: In coarse mode, `long_stall`=1 when no other thread is ready causes no switch, no flush and no hold.
- R8: `sel_pc` is the program counter of the thread in `sel_tid`. A thread's program counter grows by INSN_BYTES (4) only at the end of a cycle where that thread is granted with `sel_valid`=1.
- R9: `redir_en`=1 loads `redir_pc` into the program counter of thread `redir_tid`. This takes precedence over the step of R8 in the same cycle.
- R10: In a cycle where `mode_coarse` differs from its value in the previous cycle, the fine pointer and the coarse current thread both return to thread 0 for the next cycle, and any refill hold is cleared.
- R11: After reset, `flush_req`=0 and `hold_commit`=0, the fine pointer and coarse thread are 0, and thread i's program counter is i*RESET_STRIDE (0x1000 by default).
- R12: In fine mode, `long_stall` is ignored: rotation continues and `flush_req` and `hold_commit` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_coarse | input | 1 | 0: interleave every cycle, 1: switch only on an expensive stall |
| thr_ready | input | NUM_THREADS | Per-thread ready (1) / stalled (0) |
| long_stall | input | 1 | The current coarse thread has hit an expensive stall |
| redir_en | input | 1 | Load a thread's program counter |
| redir_tid | input | TID_W | Thread whose program counter is loaded |
| redir_pc | input | PC_W | Value to load |
| sel_tid | output | TID_W | Thread owning the slot this cycle |
| sel_valid | output | 1 | The slot is used by `sel_tid` |
| sel_pc | output | PC_W | Program counter of `sel_tid` |
| flush_req | output | 1 | One-cycle pipeline drain/freeze request after a coarse switch |
| hold_commit | output | 1 | Completion blocked while the new thread refills the pipeline |

## Verification
The bench targets the wrap-around cases of the circular search. A thread gap must be skipped, not stalled on, and a coarse switch from the highest-ready thread must wrap to thread 0. A scan that did not wrap would get stuck or pick a stalled thread. It also checks that the pointer holds through cycles with nothing ready: a design that advanced anyway would break fairness when threads come back. Other targets are the exact width of the flush pulse and of the refill window, a long stall with no alternative thread (a careless design would flush into the same thread), and a redirect in the same cycle as a step (a wrong priority leaves the PC four bytes off). The mode change is checked by watching thread 0 granted twice in a row. A design that did not reset the pointer would go on to thread 1.

// File: rtl/mts_pkg.sv
package mts_pkg;

    typedef enum logic {
        POL_FINE   = 1'b0,
        POL_COARSE = 1'b1
    } policy_e;

endpackage

// File: rtl/mts_rr_pick.sv
module mts_rr_pick #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] idx
);

    logic [IW:0] pos;

    // Scan from the farthest candidate back to start so the nearest one wins.
    always_comb begin
        found = 1'b0;
        idx   = start;
        pos   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            pos = {1'b0, start} + (IW+1)'(k);
            if (pos >= (IW+1)'(N)) begin
                pos = pos - (IW+1)'(N);
            end
            if (req[pos[IW-1:0]]) begin
                found = 1'b1;
                idx   = pos[IW-1:0];
            end
        end
    end

endmodule

// File: rtl/mts_pc_bank.sv
module mts_pc_bank #(
    parameter int          N          = 4,
    parameter int          PC_W       = 32,
    parameter int          STEP       = 4,
    parameter logic [31:0] STRIDE     = 32'h1000,
    parameter int          IW         = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv_en,
    input  logic [IW-1:0]   adv_tid,
    input  logic            ld_en,
    input  logic [IW-1:0]   ld_tid,
    input  logic [PC_W-1:0] ld_val,
    input  logic [IW-1:0]   rd_tid,
    output logic [PC_W-1:0] rd_pc
);

    logic [PC_W-1:0] pc_d [N];
    logic [PC_W-1:0] pc_q [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            pc_d[i] = pc_q[i];
            if (ld_en && (ld_tid == IW'(i))) begin
                pc_d[i] = ld_val;
            end else if (adv_en && (adv_tid == IW'(i))) begin
                pc_d[i] = pc_q[i] + PC_W'(STEP);
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                pc_q[i] <= PC_W'(i) * PC_W'(STRIDE);
            end else begin
                pc_q[i] <= pc_d[i];
            end
        end
    end

    assign rd_pc = pc_q[rd_tid];

    generate
        for (genvar g = 0; g < N; g++) begin : g_chk
            // R8: an untouched thread keeps its program counter
            p_pc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (!(adv_en && adv_tid == IW'(g)) && !(ld_en && ld_tid == IW'(g)))
                |=> $stable(pc_q[g]));
            // R9: a load wins over a step
            p_pc_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (ld_en && ld_tid == IW'(g)) |=> (pc_q[g] == $past(ld_val)));
        end
    endgenerate

endmodule

// File: rtl/mt_thread_sel.sv
module mt_thread_sel
    import mts_pkg::*;
#(
    parameter int          NUM_THREADS  = 4,
    parameter int          PC_W         = 32,
    parameter int          INSN_BYTES   = 4,
    parameter int          REFILL_CYC   = 3,
    parameter logic [31:0] RESET_STRIDE = 32'h1000,
    parameter int          TID_W        = $clog2(NUM_THREADS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mode_coarse,
    input  logic [NUM_THREADS-1:0] thr_ready,
    input  logic                   long_stall,
    input  logic                   redir_en,
    input  logic [TID_W-1:0]       redir_tid,
    input  logic [PC_W-1:0]        redir_pc,
    output logic [TID_W-1:0]       sel_tid,
    output logic                   sel_valid,
    output logic [PC_W-1:0]        sel_pc,
    output logic                   flush_req,
    output logic                   hold_commit
);

    localparam int RCW = $clog2(REFILL_CYC + 2);
    localparam logic [TID_W-1:0] LAST_TID = TID_W'(NUM_THREADS - 1);

    typedef struct packed {
        logic [TID_W-1:0] ptr;
        logic [TID_W-1:0] cur;
        policy_e          pol;
        logic             flush;
        logic [RCW-1:0]   refill;
    } sel_state_t;

    sel_state_t st_d, st_q;

    function automatic logic [TID_W-1:0] tid_next(input logic [TID_W-1:0] t);
        return (t == LAST_TID) ? '0 : t + 1'b1;
    endfunction

    policy_e pol_in;
    logic    mode_chg;
    assign pol_in   = mode_coarse ? POL_COARSE : POL_FINE;
    assign mode_chg = (pol_in != st_q.pol);

    // Fine-mode candidate: scan from the rotating pointer.
    logic             fine_found;
    logic [TID_W-1:0] fine_idx;
    mts_rr_pick #(.N(NUM_THREADS), .IW(TID_W)) u_fine_pick (
        .req   (thr_ready),
        .start (st_q.ptr),
        .found (fine_found),
        .idx   (fine_idx)
    );

    // Coarse-mode successor: any ready thread other than the current one.
    logic [NUM_THREADS-1:0] other_req;
    logic                   alt_found;
    logic [TID_W-1:0]       alt_idx;
    always_comb begin
        other_req = thr_ready;
        other_req[st_q.cur] = 1'b0;
    end
    mts_rr_pick #(.N(NUM_THREADS), .IW(TID_W)) u_alt_pick (
        .req   (other_req),
        .start (tid_next(st_q.cur)),
        .found (alt_found),
        .idx   (alt_idx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pol   = pol_in;
        st_d.flush = 1'b0;
        if (st_q.refill != '0) begin
            st_d.refill = st_q.refill - 1'b1;
        end
        if (mode_chg) begin
            st_d.ptr    = '0;
            st_d.cur    = '0;
            st_d.refill = '0;
        end else if (pol_in == POL_FINE) begin
            if (fine_found) begin
                st_d.ptr = tid_next(fine_idx);
            end
        end else if (long_stall && alt_found) begin
            st_d.cur    = alt_idx;
            st_d.flush  = 1'b1;
            st_d.refill = RCW'(REFILL_CYC);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ptr: '0, cur: '0, pol: POL_FINE, flush: 1'b0, refill: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_tid     = (pol_in == POL_COARSE) ? st_q.cur : fine_idx;
    assign sel_valid   = (pol_in == POL_COARSE) ? thr_ready[st_q.cur] : fine_found;
    assign flush_req   = st_q.flush;
    assign hold_commit = (st_q.refill != '0);

    mts_pc_bank #(
        .N      (NUM_THREADS),
        .PC_W   (PC_W),
        .STEP   (INSN_BYTES),
        .STRIDE (RESET_STRIDE),
        .IW     (TID_W)
    ) u_pcs (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_en  (sel_valid),
        .adv_tid (sel_tid),
        .ld_en   (redir_en),
        .ld_tid  (redir_tid),
        .ld_val  (redir_pc),
        .rd_tid  (sel_tid),
        .rd_pc   (sel_pc)
    );

    // R2: a stalled thread is never granted in fine mode
    p_fine_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_coarse && sel_valid) |-> thr_ready[sel_tid]);

    // R3: nothing ready means no grant
    p_idle_novalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_coarse && thr_ready == '0) |-> !sel_valid);

    // R4: coarse thread is steady unless a switch was just taken
    p_coarse_stay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_coarse && st_q.pol == POL_COARSE && $past(st_q.pol) == POL_COARSE && !flush_req)
        |-> $stable(sel_tid));

    // R5: a flush follows a long stall in coarse mode and lands on a new thread
    p_flush_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> ($past(long_stall) && $past(mode_coarse) && sel_tid != $past(sel_tid)));

    // R12: fine mode never asks for a flush
    p_fine_noflush_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(mode_coarse) && !mode_coarse) |-> !flush_req);

    generate
        if (REFILL_CYC > 0) begin : g_hold_chk
            // R6: the refill window opens together with the flush pulse
            p_hold_with_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
                flush_req |-> hold_commit);
        end
    endgenerate

endmodule

// File: tb/test_mt_thread_sel.sv
module test_mt_thread_sel;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_coarse;
    logic [3:0]  thr_ready;
    logic        long_stall;
    logic        redir_en;
    logic [1:0]  redir_tid;
    logic [31:0] redir_pc;
    logic [1:0]  sel_tid;
    logic        sel_valid;
    logic [31:0] sel_pc;
    logic        flush_req;
    logic        hold_commit;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mt_thread_sel i_mt_thread_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_coarse (mode_coarse),
        .thr_ready   (thr_ready),
        .long_stall  (long_stall),
        .redir_en    (redir_en),
        .redir_tid   (redir_tid),
        .redir_pc    (redir_pc),
        .sel_tid     (sel_tid),
        .sel_valid   (sel_valid),
        .sel_pc      (sel_pc),
        .flush_req   (flush_req),
        .hold_commit (hold_commit)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Advance one clock; inputs change and outputs are read at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; mode_coarse = 1'b0; thr_ready = '0; long_stall = 1'b0;
        redir_en = 1'b0; redir_tid = '0; redir_pc = '0;
        step(); step();
        @(negedge clk);
        rst_n = 1'b1;
        settle();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R11 valid idle", sel_valid, 0);
        chk("R11 flush", flush_req, 0);
        chk("R11 hold", hold_commit, 0);
        thr_ready = 4'b0100; settle();
        chk("R11 tid", sel_tid, 2);
        chk("R11 pc thread2", sel_pc, 32'h2000);
        thr_ready = 4'b1000; settle();
        chk("R11 pc thread3", sel_pc, 32'h3000);
    endtask

    task automatic t_fine_rotate();
        do_reset();
        thr_ready = 4'b1111; settle();
        for (int c = 0; c < 4; c++) begin
            chk("R1 rotate tid", sel_tid, c);
            chk("R8 pc of granted", sel_pc, c * 32'h1000);
            step();
        end
        chk("R1 wrap tid", sel_tid, 0);
        chk("R8 pc stepped", sel_pc, 32'h4);
    endtask

    task automatic t_fine_skip();
        logic [1:0] exp_seq [5] = '{2'd0, 2'd1, 2'd3, 2'd0, 2'd1};
        do_reset();
        thr_ready = 4'b1011; settle();
        for (int c = 0; c < 5; c++) begin
            chk("R2 skip stalled tid", sel_tid, exp_seq[c]);
            chk("R2 valid", sel_valid, 1);
            step();
        end
    endtask

    task automatic t_fine_idle();
        do_reset();
        thr_ready = 4'b0001; settle();
        chk("R3 first grant", sel_tid, 0);
        step();
        thr_ready = 4'b0000; settle();
        chk("R3 no valid", sel_valid, 0);
        step();
        chk("R3 still no valid", sel_valid, 0);
        step();
        thr_ready = 4'b1111; settle();
        chk("R3 pointer held", sel_tid, 1);
        chk("R8 thread1 pc untouched", sel_pc, 32'h1000);
    endtask

    task automatic t_fine_long_ignored();
        do_reset();
        thr_ready = 4'b1111; long_stall = 1'b1; settle();
        step();
        chk("R12 rotation continues", sel_tid, 1);
        chk("R12 no flush", flush_req, 0);
        chk("R12 no hold", hold_commit, 0);
        long_stall = 1'b0;
    endtask

    task automatic t_coarse();
        do_reset();
        mode_coarse = 1'b1; thr_ready = 4'b1111; settle();
        for (int c = 0; c < 3; c++) begin
            chk("R4 stay on thread0", sel_tid, 0);
            chk("R8 coarse pc", sel_pc, c * 4);
            step();
        end
        thr_ready = 4'b1110; settle();
        chk("R4 short stall valid", sel_valid, 0);
        step();
        chk("R4 short stall no switch", sel_tid, 0);
        chk("R4 short stall no flush", flush_req, 0);
        chk("R8 stalled pc held", sel_pc, 32'hC);
        long_stall = 1'b1; settle();
        step();
        long_stall = 1'b0; settle();
        chk("R5 switched tid", sel_tid, 1);
        chk("R5 flush pulse", flush_req, 1);
        chk("R6 hold c1", hold_commit, 1);
        chk("R8 new thread pc", sel_pc, 32'h1000);
        step();
        chk("R5 flush one cycle", flush_req, 0);
        chk("R6 hold c2", hold_commit, 1);
        chk("R8 new thread stepped", sel_pc, 32'h1004);
        step();
        chk("R6 hold c3", hold_commit, 1);
        step();
        chk("R6 hold ends", hold_commit, 0);
        // wrap: from thread 1, only thread 0 ready besides
        thr_ready = 4'b0001; long_stall = 1'b1; settle();
        step();
        long_stall = 1'b0; settle();
        chk("R5 wrap to thread0", sel_tid, 0);
        chk("R5 wrap flush", flush_req, 1);
        // no alternative
        step(); step(); step();
        thr_ready = 4'b0000; long_stall = 1'b1; settle();
        step();
        chk("R7 no switch", sel_tid, 0);
        chk("R7 no flush", flush_req, 0);
        chk("R7 no hold", hold_commit, 0);
        long_stall = 1'b0;
    endtask

    task automatic t_redirect();
        do_reset();
        thr_ready = 4'b0001; settle();
        redir_en = 1'b1; redir_tid = 2'd0; redir_pc = 32'h8000; settle();
        step();
        redir_en = 1'b0; settle();
        chk("R9 load beats step", sel_pc, 32'h8000);
        redir_en = 1'b1; redir_tid = 2'd3; redir_pc = 32'h500; settle();
        step();
        redir_en = 1'b0;
        thr_ready = 4'b1000; settle();
        chk("R9 other thread loaded tid", sel_tid, 3);
        chk("R9 other thread loaded pc", sel_pc, 32'h500);
    endtask

    task automatic t_mode_change();
        do_reset();
        mode_coarse = 1'b1; thr_ready = 4'b1110; settle();
        step();
        long_stall = 1'b1; settle();
        step();
        long_stall = 1'b0; settle();
        chk("R10 coarse on thread1", sel_tid, 1);
        step(); step(); step();
        mode_coarse = 1'b0; thr_ready = 4'b1111; settle();
        chk("R10 change cycle tid", sel_tid, 0);
        step();
        chk("R10 pointer back at 0", sel_tid, 0);
        chk("R10 hold cleared", hold_commit, 0);
        step();
        chk("R10 rotation resumes", sel_tid, 1);
    endtask

    initial begin
        rst_n = 1'b0; mode_coarse = 1'b0; thr_ready = '0; long_stall = 1'b0;
        redir_en = 1'b0; redir_tid = '0; redir_pc = '0;
        t_reset();
        t_fine_rotate();
        t_fine_skip();
        t_fine_idle();
        t_fine_long_ignored();
        t_coarse();
        t_redirect();
        t_mode_change();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule